// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block is the host end of a read from a 12-bit converter with a serial output. A one-cycle `start` pulse opens a frame. The block pulls the active-low select line low and produces a serial clock by dividing the system clock. It then samples the converter's data line once per serial clock period and hands back the twelve data bits with a single-cycle valid strobe.

A frame is sixteen serial clock periods long. The converter first sends four leading zeros, then twelve data bits with the most significant bit first, and no trailing bits. The serial clock can rest high or low between frames, and this decides whether the first edge after select falls is a falling or a rising edge. The parameter `FIRST_EDGE_FALLING` picks the resting level. In both cases the block counts falling edges from the moment select falls, so the same edges always load the result and the result is never shifted by one bit.

In the falling-first case, the very first leading zero is on the line only for a short time before the first edge. The block therefore leaves that bit out of its framing check. A leading-zero position that reads 1 in any other place sets an error flag for that frame. The result port is a pure source with no back-pressure: `res_valid` is high for exactly one cycle and there is no ready input. A consumer that needs the word must take it in that cycle, or read `res_data` later, since it holds until the next frame ends.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, and whenever reset is applied, `adc_cs_n` is 1, `adc_sclk` is at its resting level, and `busy`, `res_valid`, `res_lead_err` and `res_data` are all 0.
- R2: A `start` sampled high while `busy` is 0 pulls `adc_cs_n` low and raises `busy` on that same clock edge.
- R3: The resting level of `adc_sclk` is 1 when `FIRST_EDGE_FALLING`=1 (so the first edge is falling) and 0 when it is 0 (so the first edge is rising). The first edge comes `HALF_DIV` cycles after select falls. Each level lasts `HALF_DIV` cycles, and exactly 16 falling edges occur while `adc_cs_n` is low.
- R4: `res_data` holds the line values sampled at falling edges 5 through 16, counted from select going low. The value at edge 5 lands in bit 11 (most significant) and the value at edge 16 lands in bit 0.
- R5: `res_valid` is high for exactly one cycle, on the edge where `adc_cs_n` returns high, which is 33·`HALF_DIV` cycles after the start edge. `res_data` and `res_lead_err` keep their values until the next such pulse.
- R6: `res_lead_err` is 1 when any line value sampled at a leading-zero edge is 1. The leading-zero edges are falling edges 1–4 when `FIRST_EDGE_FALLING`=0 and edges 2–4 when it is 1. In the falling-first case, the bit present before the first edge is ignored.
- R7: `busy` stays high for `QUIET_CYC` cycles after `adc_cs_n` rises and then falls. A `start` pulse that arrives while `busy` is high is ignored and does not open a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to read one frame |
| busy | output | 1 | High from an accepted start until the quiet time ends |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdata | input | 1 | Serial data from the converter |
| res_data | output | DATA_BITS | Captured result, MSB first on the wire |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_lead_err | output | 1 | Leading-zero framing error for the latest frame |

## Verification
Select and `busy` respond on the start edge itself. The first serial clock edge is due `HALF_DIV` cycles later. `res_valid`, the new `res_data` and `res_lead_err` are due exactly 33·`HALF_DIV` cycles after the start edge, and `busy` drops `QUIET_CYC` cycles after that. The bench drives inputs and samples outputs on the falling system clock edge. It counts cycles from the start edge and compares each result against the cycle number derived from these formulas. It does not simply wait for the strobe. Both resting levels of the serial clock are exercised against a converter model that changes its output on every falling edge.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_QUIET = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_frame_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int QUIET_CYC = 6,
  parameter int TOGGLES = 32,
  parameter bit IDLE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cs_n,
  output logic sclk,
  output logic busy,
  output logic fall_tick,
  output logic frame_open,
  output logic frame_close
);
  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int QCW = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;
  localparam int TCW = $clog2(TOGGLES + 1);

  seq_state_e st;
  logic [HCW-1:0] half_cnt;
  logic [QCW-1:0] quiet_cnt;
  logic [TCW-1:0] tog_cnt;
  logic half_done;

  assign half_done   = (half_cnt == HCW'(HALF_DIV - 1));
  assign frame_open  = (st == SEQ_IDLE) && start;
  assign frame_close = (st == SEQ_SHIFT) && half_done && (tog_cnt == TCW'(TOGGLES));
  assign busy        = (st != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      half_cnt  <= '0;
      quiet_cnt <= '0;
      tog_cnt   <= '0;
      cs_n      <= 1'b1;
      sclk      <= IDLE_HIGH;
      fall_tick <= 1'b0;
    end else begin
      fall_tick <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            st       <= SEQ_SHIFT;
            cs_n     <= 1'b0;
            half_cnt <= '0;
            tog_cnt  <= '0;
          end
        end
        SEQ_SHIFT: begin
          if (half_done) begin
            half_cnt <= '0;
            if (tog_cnt != TCW'(TOGGLES)) begin
              sclk      <= ~sclk;
              tog_cnt   <= tog_cnt + 1'b1;
              fall_tick <= sclk;
            end else begin
              cs_n      <= 1'b1;
              st        <= SEQ_QUIET;
              quiet_cnt <= '0;
            end
          end else begin
            half_cnt <= half_cnt + 1'b1;
          end
        end
        SEQ_QUIET: begin
          if (quiet_cnt == QCW'(QUIET_CYC - 1)) st <= SEQ_IDLE;
          else quiet_cnt <= quiet_cnt + 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  a_r3_sclk_rests_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == IDLE_HIGH));
  a_r3_sclk_still_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sclk));
  a_r7_busy_covers_select: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  a_r7_start_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_n) |=> cs_n);
endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
  parameter int LEAD_BITS = 4,
  parameter int DATA_BITS = 12,
  parameter int FIRST_CHECKED = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdata,
  input  logic                 clear,
  input  logic                 fall_tick,
  output logic [DATA_BITS-1:0] data_word,
  output logic                 lead_err
);
  localparam int FRAME = LEAD_BITS + DATA_BITS;
  localparam int FW = $clog2(FRAME + 1);

  logic          sd_q;
  logic [FW-1:0] fall_idx;
  logic [FW-1:0] fall_num;

  assign fall_num = fall_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q      <= 1'b0;
      fall_idx  <= '0;
      data_word <= '0;
      lead_err  <= 1'b0;
    end else begin
      sd_q <= sdata;
      if (clear) begin
        fall_idx <= '0;
        lead_err <= 1'b0;
      end else if (fall_tick) begin
        fall_idx <= fall_num;
        if (fall_num > FW'(LEAD_BITS)) begin
          data_word <= {data_word[DATA_BITS-2:0], sd_q};
        end else if (fall_num >= FW'(FIRST_CHECKED) && sd_q) begin
          lead_err <= 1'b1;
        end
      end
    end
  end

  a_r3_falls_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (fall_idx < FW'(FRAME)));
  a_r6_error_sticky_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_err && !clear) |=> lead_err);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_BITS = 12,
  parameter int LEAD_BITS = 4,
  parameter int HALF_DIV = 2,
  parameter int QUIET_CYC = 6,
  parameter bit FIRST_EDGE_FALLING = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  input  logic                 adc_sdata,
  output logic [DATA_BITS-1:0] res_data,
  output logic                 res_valid,
  output logic                 res_lead_err
);
  localparam int FRAME = LEAD_BITS + DATA_BITS;
  localparam int TOGGLES = 2 * FRAME;
  localparam int FIRST_CHECKED = FIRST_EDGE_FALLING ? 2 : 1;

  logic fall_tick, frame_open, frame_close;
  logic [DATA_BITS-1:0] shift_word;
  logic shift_err;

  adc_seq_ctrl #(
    .HALF_DIV(HALF_DIV), .QUIET_CYC(QUIET_CYC),
    .TOGGLES(TOGGLES), .IDLE_HIGH(FIRST_EDGE_FALLING)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .busy(busy),
    .fall_tick(fall_tick), .frame_open(frame_open), .frame_close(frame_close)
  );

  adc_bit_capture #(
    .LEAD_BITS(LEAD_BITS), .DATA_BITS(DATA_BITS), .FIRST_CHECKED(FIRST_CHECKED)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .sdata(adc_sdata),
    .clear(frame_open), .fall_tick(fall_tick),
    .data_word(shift_word), .lead_err(shift_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data     <= '0;
      res_lead_err <= 1'b0;
      res_valid    <= 1'b0;
    end else begin
      res_valid <= frame_close;
      if (frame_close) begin
        res_data     <= shift_word;
        res_lead_err <= shift_err;
      end
    end
  end

  a_r2_start_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!adc_cs_n && busy));
  a_r5_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r5_valid_on_select_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> res_valid);
  a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_data) && $stable(res_lead_err)));
endmodule

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_dev_model (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [15:0] word,
  output logic        sdo
);
  int idx;
  bit active;
  initial begin
    sdo = 1'b0;
    idx = 0;
    active = 1'b0;
  end
  always @(negedge cs_n or posedge cs_n or negedge sclk) begin
    if (cs_n) begin
      active = 1'b0;
      sdo <= #1 1'b0;
    end else if (!active) begin
      active = 1'b1;
      idx = 0;
      sdo <= #1 word[15];
    end else begin
      idx = idx + 1;
      sdo <= #1 ((idx < 16) ? word[15 - idx] : 1'b0);
    end
  end
endmodule

module adc_frame_reader_test;
  localparam int HALF = 2;
  localparam int QUIET = 6;
  localparam int LAT = 33 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_f = 1'b0, start_r = 1'b0;
  logic busy_f, busy_r, cs_f, cs_r, sclk_f, sclk_r, sd_f, sd_r;
  logic val_f, val_r, err_f, err_r;
  logic [11:0] res_f, res_r;
  logic [15:0] word_f = '0, word_r = '0;

  int checks = 0, fails = 0;
  int falls_f = 0, falls_r = 0;
  bit sel = 1'b0;
  logic cs_m, sclk_m, busy_m, val_m, err_m;
  logic [11:0] res_m;

  always #4 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(HALF), .QUIET_CYC(QUIET), .FIRST_EDGE_FALLING(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start_f), .busy(busy_f), .adc_cs_n(cs_f),
    .adc_sclk(sclk_f), .adc_sdata(sd_f), .res_data(res_f), .res_valid(val_f),
    .res_lead_err(err_f));
  adc_frame_reader #(.HALF_DIV(HALF), .QUIET_CYC(QUIET), .FIRST_EDGE_FALLING(1'b0)) uut_r (
    .clk(clk), .rst_n(rst_n), .start(start_r), .busy(busy_r), .adc_cs_n(cs_r),
    .adc_sclk(sclk_r), .adc_sdata(sd_r), .res_data(res_r), .res_valid(val_r),
    .res_lead_err(err_r));

  adc_dev_model dev_f (.cs_n(cs_f), .sclk(sclk_f), .word(word_f), .sdo(sd_f));
  adc_dev_model dev_r (.cs_n(cs_r), .sclk(sclk_r), .word(word_r), .sdo(sd_r));

  always @(negedge sclk_f) if (!cs_f) falls_f++;
  always @(negedge sclk_r) if (!cs_r) falls_r++;

  always_comb begin
    cs_m   = sel ? cs_r : cs_f;
    sclk_m = sel ? sclk_r : sclk_f;
    busy_m = sel ? busy_r : busy_f;
    val_m  = sel ? val_r : val_f;
    err_m  = sel ? err_r : err_f;
    res_m  = sel ? res_r : res_f;
  end

  // word, expected result, expected error (falling-first), expected error (rising-first)
  localparam logic [29:0] VEC [8] = '{
    {16'h0000, 12'h000, 1'b0, 1'b0},
    {16'h0FFF, 12'hFFF, 1'b0, 1'b0},
    {16'h0A5C, 12'hA5C, 1'b0, 1'b0},
    {16'h0801, 12'h801, 1'b0, 1'b0},
    {16'h8123, 12'h123, 1'b0, 1'b1},
    {16'h4ABC, 12'hABC, 1'b1, 1'b1},
    {16'h1001, 12'h001, 1'b1, 1'b1},
    {16'h0555, 12'h555, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input bit r, input logic [15:0] w, input logic [11:0] er, input bit ee);
    int cyc;
    int f0;
    logic [11:0] prev;
    logic idle_lvl;
    sel = r;
    idle_lvl = r ? 1'b0 : 1'b1;
    if (r) word_r = w; else word_f = w;
    @(negedge clk);
    prev = res_m;
    f0 = r ? falls_r : falls_f;
    if (r) start_r = 1'b1; else start_f = 1'b1;
    @(negedge clk);
    start_r = 1'b0; start_f = 1'b0;
    chk("R2 select low after start", cs_m == 1'b0, cs_m, 0);
    chk("R2 busy after start", busy_m == 1'b1, busy_m, 1);
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == HALF - 1) chk("R3 sclk at rest before first edge", sclk_m == idle_lvl, sclk_m, idle_lvl);
      if (cyc == HALF) chk("R3 first sclk edge polarity", sclk_m == !idle_lvl, sclk_m, !idle_lvl);
      if (cyc == 10) chk("R5 result held during next frame", res_m == prev, res_m, prev);
      if (val_m || cyc > 1000) break;
    end
    chk("R5 valid latency", cyc == LAT, cyc, LAT);
    chk("R5 select high with valid", cs_m == 1'b1, cs_m, 1);
    chk("R4 result word", res_m == er, res_m, er);
    chk("R6 leading-zero flag", err_m == ee, err_m, ee);
    chk("R3 falling edges per frame", ((r ? falls_r : falls_f) - f0) == 16, (r ? falls_r : falls_f) - f0, 16);
    @(negedge clk);
    cyc++;
    chk("R5 valid is one cycle", val_m == 1'b0, val_m, 0);
    chk("R5 result held after valid", res_m == er, res_m, er);
    if (r) start_r = 1'b1; else start_f = 1'b1;
    @(negedge clk);
    cyc++;
    start_r = 1'b0; start_f = 1'b0;
    while (busy_m && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R7 busy covers quiet time", cyc == LAT + QUIET, cyc, LAT + QUIET);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 start in quiet ignored", cs_m == 1'b1 && busy_m == 1'b0, cs_m, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset select", cs_f && cs_r, {cs_f, cs_r}, 3);
    chk("R1 reset sclk rest levels R3", sclk_f == 1'b1 && sclk_r == 1'b0, {sclk_f, sclk_r}, 2);
    chk("R1 reset busy", !busy_f && !busy_r, {busy_f, busy_r}, 0);
    chk("R1 reset outputs", !val_f && !val_r && !err_f && !err_r && res_f == 0 && res_r == 0,
        {val_f, val_r, err_f, err_r}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 state after release", cs_f && !busy_f && sclk_f, {cs_f, busy_f, sclk_f}, 5);

    for (int i = 0; i < 8; i++) begin
      run_frame(1'b0, VEC[i][29:14], VEC[i][13:2], VEC[i][1]);
      run_frame(1'b1, VEC[i][29:14], VEC[i][13:2], VEC[i][0]);
    end

    // reset in the middle of a frame
    sel = 1'b1;
    word_r = 16'h0ABC;
    @(negedge clk) start_r = 1'b1;
    @(negedge clk) start_r = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 frame running before reset", cs_r == 1'b0, cs_r, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame reset select", cs_r == 1'b1 && sclk_r == 1'b0, {cs_r, sclk_r}, 2);
    chk("R1 mid-frame reset outputs", !busy_r && !val_r && res_r == 0 && !err_r, {busy_r, res_r}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(1'b1, 16'h0F0F, 12'hF0F, 1'b0);
    run_frame(1'b0, 16'hF000, 12'h000, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule